// File: doc/BRIEF.md
# Bipolar Substitution Decoder with Line-Code Violation Detection

This block sits on the receive side of a bipolar line interface and runs on the recovered clock. It takes one positive-rail and one negative-rail pulse indication per bit period. It works in one of two ways. In raw mode it forwards both rails unchanged. In decode mode it removes zero-substitution patterns and delivers NRZ data, and it reuses the negative output as a one-cycle line-code-violation flag.

Two substitution codes can be chosen at runtime. The 3-zero code is used at the ~45 and ~52 Mbit/s rates. The 4-zero code is used at the ~34 Mbit/s rate. Three kinds of violation are merged onto the single flag: a zero run that is too long, a violation pulse that comes too soon after a pulse, and a wrong pulse parity between violation pulses. A loss-of-signal input forces both data outputs low. A three-level polarity control can invert the clock that goes out with the data.

Top module: `bipolar_subst_decoder`

## Requirements
- R1: With `rawMode`=1 and `sigLost`=0, `dataPos`/`dataNeg` equal `posIn`/`negIn` as sampled at the previous rising edge (one clock of latency).
- R2: With `rawMode`=0, a symbol sampled at edge k has its decoded bit on `dataPos` and its violation flag on `dataNeg` after edge k+4. An ordinary pulse decodes to 1, and a zero that is not flagged decodes to 0.
- R3: `hdb3Sel`=0 selects the 3-zero code. A violation pulse preceded by exactly one zero is a substitution (B0V or 00V). `hdb3Sel`=1 selects the 4-zero code. A violation pulse preceded by two zeros is a substitution (B00V or 000V). Every pulse in a recognised substitution decodes to 0.
- R4: A pulse with the same polarity as the previous pulse since reset is a violation pulse (V). Any other pulse, including the first one after reset, is an ordinary pulse (B).
- R5: The flag is raised on the zero that makes the current zero run 3 long (`hdb3Sel`=0) or 4 long (`hdb3Sel`=1). It is raised once per run.
- R6: The flag is raised on a V that directly follows a pulse. With `hdb3Sel`=1 it is also raised on a V that follows a pulse and then one zero. Such a V is not treated as a substitution and decodes to 1.
- R7: The flag is raised on a V when an even number of B pulses was received since the previous V. The first V after reset is never flagged this way.
- R8: When `sigLost` is sampled high at an edge, both `dataPos` and `dataNeg` are 0 after that edge, in either mode.
- R9: `clkPol` encodes the three-level control as 00 = low, 01 = float, 10 = high. `clkOut` is the inverse of `clk` only for 01 and equals `clk` for every other code.
- R10: While `rstN` is low, `dataPos` and `dataNeg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rstN | input | 1 | Active-low synchronous reset |
| posIn | input | 1 | Positive-rail pulse for the current bit |
| negIn | input | 1 | Negative-rail pulse for the current bit |
| rawMode | input | 1 | 1 = pass rails through, 0 = decode |
| hdb3Sel | input | 1 | 0 = 3-zero substitution code, 1 = 4-zero code |
| sigLost | input | 1 | Loss of signal; forces data outputs low |
| clkPol | input | 2 | Clock polarity control (00 low, 01 float, 10 high) |
| clkOut | output | 1 | Receive clock, inverted only for code 01 |
| dataPos | output | 1 | Positive rail (raw) or NRZ data (decode) |
| dataNeg | output | 1 | Negative rail (raw) or violation flag (decode) |

## Verification
The bench drives long random NRZ streams through an encoder model for each code, and expects the data back unchanged with no flags. This catches a design that removes the wrong pulse of a substitution, misaligns the four-clock delay, or fires a parity or zero-run flag on legal traffic. Directed streams then target the boundaries one at a time. They check the exact zero on which a run becomes too long in each code. They check a pattern of pulse, zero, same-polarity pulse: it is a legal substitution in the 3-zero code but a violation in the 4-zero code, so a design that mixes up the windows would decode or flag it wrongly. They also check an even pulse count between two substitutions, which a design with the parity sense reversed would pass silently. Further checks cover loss of signal in both modes and every polarity code, including the unused fourth code.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  // Strobes from the control unit to the datapath, one set per clock.
  typedef struct packed {
    logic keepNew;   // data bit stored for the incoming symbol
    logic violNew;   // violation flag stored for the incoming symbol
    logic killAge1;  // clear the pulse two symbols back (3-zero code)
    logic killAge2;  // clear the pulse three symbols back (4-zero code)
  } bsdStrobe_t;

  // One stage of the decode delay line.
  typedef struct packed {
    logic data;
    logic viol;
  } bsdSlot_t;

endpackage

// File: rtl/bsd_ctrl.sv
module bsd_ctrl
  import bsd_pkg::*;
#(
  parameter int ZCW = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       posIn,
  input  logic       negIn,
  input  logic       hdb3Sel,
  output bsdStrobe_t strobe
);

  localparam int HIST = 3;
  localparam logic [ZCW-1:0] RUN_SHORT = ZCW'(2);
  localparam logic [ZCW-1:0] RUN_LONG  = ZCW'(3);

  logic            pulseNow;
  logic            polNow;
  logic            lastPol;
  logic            seenPulse;
  logic            seenV;
  logic            bOdd;
  logic [HIST-1:0] hist;      // hist[0] = previous symbol had a pulse
  logic [ZCW-1:0]  zeroRun;
  logic [ZCW-1:0]  zeroLimit;
  logic            isV;
  logic            isB;
  logic            runViol;
  logic            bvViol;
  logic            parViol;
  logic            substOk;

  assign pulseNow  = posIn | negIn;
  assign polNow    = posIn;
  assign isV       = pulseNow && seenPulse && (polNow == lastPol);
  assign isB       = pulseNow && !isV;
  assign zeroLimit = hdb3Sel ? RUN_LONG : RUN_SHORT;

  always_comb begin
    runViol = !pulseNow && (zeroRun == zeroLimit);
    bvViol  = isV && (hist[0] || (hdb3Sel && hist[1]));
    parViol = isV && seenV && !bOdd;
    if (hdb3Sel) substOk = isV && !hist[0] && !hist[1];
    else         substOk = isV && !hist[0];
    strobe.keepNew  = pulseNow && !substOk;
    strobe.violNew  = runViol || bvViol || parViol;
    strobe.killAge1 = substOk && !hdb3Sel && hist[1];
    strobe.killAge2 = substOk && hdb3Sel && hist[2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastPol   <= 1'b0;
      seenPulse <= 1'b0;
      seenV     <= 1'b0;
      bOdd      <= 1'b0;
      hist      <= '0;
      zeroRun   <= '0;
    end else begin
      hist <= {hist[HIST-2:0], pulseNow};
      if (pulseNow) begin
        lastPol   <= polNow;
        seenPulse <= 1'b1;
        zeroRun   <= '0;
      end else if (zeroRun != '1) begin
        zeroRun <= zeroRun + 1'b1;
      end
      if (isV) begin
        seenV <= 1'b1;
        bOdd  <= 1'b0;
      end else if (isB) begin
        bOdd <= ~bOdd;
      end
    end
  end

  // Age since reset, used only to keep $past inside the post-reset window.
  logic [1:0] ageCnt;
  always_ff @(posedge clk) begin
    if (!rstN)             ageCnt <= '0;
    else if (ageCnt != '1) ageCnt <= ageCnt + 1'b1;
  end

  // R5: in the 3-zero code the third zero after a pulse is flagged.
  a_r5_third_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt == 2'd3 && !hdb3Sel && !posIn && !negIn
     && $past(!posIn && !negIn) && $past(!posIn && !negIn, 2)
     && $past(posIn || negIn, 3)) |-> strobe.violNew);

  // R6: two positive pulses in a row give a flag on the second one.
  a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt != 2'd0 && posIn && !negIn && $past(posIn && !negIn))
    |-> strobe.violNew);

endmodule

// File: rtl/bsd_path.sv
module bsd_path
  import bsd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       posIn,
  input  logic       negIn,
  input  logic       rawMode,
  input  logic       sigLost,
  input  bsdStrobe_t strobe,
  output logic       dataPos,
  output logic       dataNeg
);

  localparam int KILL_NEAR = 1;   // stage holding the symbol two back
  localparam int KILL_FAR  = 2;   // stage holding the symbol three back

  bsdSlot_t             pipe [DEPTH];
  logic     [DEPTH-1:0] killMask;

  for (genvar i = 0; i < DEPTH; i++) begin : g_kill
    if (i == KILL_NEAR) begin : g_near
      assign killMask[i] = strobe.killAge1;
    end else if (i == KILL_FAR) begin : g_far
      assign killMask[i] = strobe.killAge2;
    end else begin : g_none
      assign killMask[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= '{data: strobe.keepNew, viol: strobe.violNew};
      for (int i = 1; i < DEPTH; i++) begin
        pipe[i].data <= pipe[i-1].data && !killMask[i-1];
        pipe[i].viol <= pipe[i-1].viol;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || sigLost) begin
      dataPos <= 1'b0;
      dataNeg <= 1'b0;
    end else if (rawMode) begin
      dataPos <= posIn;
      dataNeg <= negIn;
    end else begin
      dataPos <= pipe[DEPTH-1].data;
      dataNeg <= pipe[DEPTH-1].viol;
    end
  end

  // R8: loss of signal silences both outputs on the next cycle.
  a_r8_los_quiet: assert property (@(posedge clk) disable iff (!rstN)
    sigLost |=> (!dataPos && !dataNeg));

  // R1: raw mode forwards the rails with one clock of delay.
  a_r1_raw_follow: assert property (@(posedge clk) disable iff (!rstN)
    (rawMode && !sigLost) |=> (dataPos == $past(posIn) && dataNeg == $past(negIn)));

endmodule

// File: rtl/bipolar_subst_decoder.sv
module bipolar_subst_decoder
  import bsd_pkg::*;
#(
  parameter int PIPE_DEPTH = 4,   // decode latency; at least 4
  parameter int ZERO_CNT_W = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       posIn,
  input  logic       negIn,
  input  logic       rawMode,
  input  logic       hdb3Sel,
  input  logic       sigLost,
  input  logic [1:0] clkPol,
  output logic       clkOut,
  output logic       dataPos,
  output logic       dataNeg
);

  localparam logic [1:0] POL_FLOAT = 2'b01;

  bsdStrobe_t strobe;

  bsd_ctrl #(.ZCW(ZERO_CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .posIn   (posIn),
    .negIn   (negIn),
    .hdb3Sel (hdb3Sel),
    .strobe  (strobe)
  );

  bsd_path #(.DEPTH(PIPE_DEPTH)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .posIn   (posIn),
    .negIn   (negIn),
    .rawMode (rawMode),
    .sigLost (sigLost),
    .strobe  (strobe),
    .dataPos (dataPos),
    .dataNeg (dataNeg)
  );

  assign clkOut = (clkPol == POL_FLOAT) ? ~clk : clk;

endmodule

// File: tb/sim_bipolar_subst_decoder.sv
module sim_bipolar_subst_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int MAXN       = 512;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       posIn = 1'b0, negIn = 1'b0;
  logic       rawMode = 1'b0, hdb3Sel = 1'b0, sigLost = 1'b0;
  logic [1:0] clkPol = 2'b00;
  logic       clkOut, dataPos, dataNeg;

  bit sPos [MAXN];
  bit sNeg [MAXN];
  bit ePos [MAXN];
  bit eNeg [MAXN];
  int nSym;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bipolar_subst_decoder u0 (
    .clk(clk), .rstN(rstN), .posIn(posIn), .negIn(negIn),
    .rawMode(rawMode), .hdb3Sel(hdb3Sel), .sigLost(sigLost),
    .clkPol(clkPol), .clkOut(clkOut), .dataPos(dataPos), .dataNeg(dataNeg)
  );

  task automatic chk(string tag, int idx, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at symbol %0d: got %0b expected %0b", tag, idx, act, exp);
    end
  endtask

  task automatic clearArr();
    for (int i = 0; i < MAXN; i++) begin
      sPos[i] = 0; sNeg[i] = 0; ePos[i] = 0; eNeg[i] = 0;
    end
    nSym = 0;
  endtask

  // code: 0 = zero, 1 = positive pulse, 2 = negative pulse
  task automatic put(int i, int code, bit ep, bit en);
    sPos[i] = (code == 1);
    sNeg[i] = (code == 2);
    ePos[i] = ep;
    eNeg[i] = en;
    if (i + 1 > nSym) nSym = i + 1;
  endtask

  // Resets the block, then plays the stored stream and compares the outputs.
  task automatic runStream(bit raw, bit hdb, bit lost, string tag);
    int lat;
    rawMode = raw; hdb3Sel = hdb; sigLost = lost;
    rstN = 0; posIn = 0; negIn = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset dataPos", -1, dataPos, 1'b0);
    chk("R10 reset dataNeg", -1, dataNeg, 1'b0);
    lat = raw ? 1 : 5;
    for (int m = 0; m < nSym + lat; m++) begin
      if (m > 0) begin
        @(negedge clk);
        #1;
      end
      rstN = 1;
      if (m >= lat) begin
        chk({tag, " dataPos"}, m - lat, dataPos, ePos[m - lat]);
        chk({tag, " dataNeg"}, m - lat, dataNeg, eNeg[m - lat]);
      end
      posIn = (m < nSym) ? sPos[m] : 1'b0;
      negIn = (m < nSym) ? sNeg[m] : 1'b0;
    end
    posIn = 0; negIn = 0;
  endtask

  // Bench encoder: random NRZ to a legal substituted bipolar stream.
  task automatic encodeRandom(bit hdb, int n);
    int runLen;
    int zr = 0;
    int bCount = 0;
    bit lastPos = 0;
    clearArr();
    runLen = hdb ? 4 : 3;
    for (int i = 0; i < n; i++) begin
      bit b;
      b = 1'($urandom % 2);
      ePos[i] = b;
      eNeg[i] = 0;
      if (b) begin
        lastPos = ~lastPos;
        sPos[i] = lastPos; sNeg[i] = ~lastPos;
        bCount++;
        zr = 0;
      end else begin
        sPos[i] = 0; sNeg[i] = 0;
        zr++;
        if (zr == runLen) begin
          if (bCount % 2 == 0) begin
            lastPos = ~lastPos;
            sPos[i-runLen+1] = lastPos; sNeg[i-runLen+1] = ~lastPos;
          end
          sPos[i] = lastPos; sNeg[i] = ~lastPos;
          bCount = 0;
          zr = 0;
        end
      end
    end
    nSym = n;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));

    // R2 R3 R4: legal streams in each code decode back to the NRZ data.
    encodeRandom(1'b0, 400);
    runStream(1'b0, 1'b0, 1'b0, "R2 R3 3-zero random");
    encodeRandom(1'b1, 400);
    runStream(1'b0, 1'b1, 1'b0, "R2 R3 4-zero random");

    // R1: raw mode with random rails.
    clearArr();
    for (int i = 0; i < 200; i++) begin
      bit p, q;
      p = 1'($urandom % 2); q = 1'($urandom % 2);
      sPos[i] = p; sNeg[i] = q; ePos[i] = p; eNeg[i] = q;
    end
    nSym = 200;
    runStream(1'b1, 1'b0, 1'b0, "R1 raw");

    // R8: loss of signal in raw and decode modes.
    for (int i = 0; i < 200; i++) begin
      ePos[i] = 0; eNeg[i] = 0;
    end
    runStream(1'b1, 1'b0, 1'b1, "R8 raw los");
    encodeRandom(1'b0, 40);
    for (int i = 0; i < 40; i++) ePos[i] = 0;
    runStream(1'b0, 1'b0, 1'b1, "R8 decode los");

    // R5: third zero flagged in the 3-zero code.
    clearArr();
    put(0, 1, 1, 0); put(1, 0, 0, 0); put(2, 0, 0, 0); put(3, 0, 0, 1); put(4, 2, 1, 0);
    runStream(1'b0, 1'b0, 1'b0, "R5 3-zero run");

    // R5: three zeros legal, fourth flagged in the 4-zero code.
    clearArr();
    put(0, 1, 1, 0); put(1, 0, 0, 0); put(2, 0, 0, 0); put(3, 0, 0, 0); put(4, 2, 1, 0);
    put(5, 0, 0, 0); put(6, 0, 0, 0); put(7, 0, 0, 0); put(8, 0, 0, 1); put(9, 1, 1, 0);
    runStream(1'b0, 1'b1, 1'b0, "R5 4-zero run");

    // R6 R4: pulse then same-polarity pulse in the 3-zero code.
    clearArr();
    put(0, 1, 1, 0); put(1, 1, 1, 1); put(2, 2, 1, 0);
    runStream(1'b0, 1'b0, 1'b0, "R6 R4 B,V 3-zero");

    // R6: pulse, zero, V in the 4-zero code is a violation, not decoded.
    clearArr();
    put(0, 1, 1, 0); put(1, 0, 0, 0); put(2, 1, 1, 1); put(3, 2, 1, 0);
    runStream(1'b0, 1'b1, 1'b0, "R6 B,0,V 4-zero");

    // R3: the same pattern is a legal B0V substitution in the 3-zero code.
    clearArr();
    put(0, 1, 0, 0); put(1, 0, 0, 0); put(2, 1, 0, 0); put(3, 2, 1, 0);
    runStream(1'b0, 1'b0, 1'b0, "R3 B0V");

    // R3 R4: B00V in the 4-zero code, negative polarity.
    clearArr();
    put(0, 2, 0, 0); put(1, 0, 0, 0); put(2, 0, 0, 0); put(3, 2, 0, 0); put(4, 1, 1, 0);
    runStream(1'b0, 1'b1, 1'b0, "R3 R4 B00V");

    // R7: even B count between two substitutions is flagged on the second V.
    clearArr();
    put(0, 1, 0, 0); put(1, 0, 0, 0); put(2, 1, 0, 0); put(3, 2, 1, 0);
    put(4, 1, 0, 0); put(5, 0, 0, 0); put(6, 1, 0, 1);
    runStream(1'b0, 1'b0, 1'b0, "R7 even parity");

    // R7: odd count between V pulses raises no flag.
    clearArr();
    put(0, 1, 0, 0); put(1, 0, 0, 0); put(2, 1, 0, 0); put(3, 2, 1, 0);
    put(4, 0, 0, 0); put(5, 0, 0, 0); put(6, 2, 0, 0);
    runStream(1'b0, 1'b0, 1'b0, "R7 odd parity");

    // R9: clock polarity for every code.
    for (int c = 0; c < 4; c++) begin
      clkPol = 2'(c);
      @(negedge clk); #1;
      chk("R9 clkOut low phase", c, clkOut, (c == 1));
      @(posedge clk); #1;
      chk("R9 clkOut high phase", c, clkOut, (c != 1));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule